// File: doc/BRIEF.md
# Key Input Port Interrupt Controller

This peripheral connects four external key or switch lines to a small processor data bus. Each line passes through a two-stage synchronizer. Software reads the synchronized levels from a port data register. An enable register arms individual lines as interrupt sources. All armed lines share one interrupt factor flag. The flag is set on a rising edge of an armed line and clears when software reads it. The interrupt request output follows the flag.

Each pin can optionally route its interrupt path through a noise rejector. A pin configuration input selects this per pin. The rejector lets a level change through only after it has held for `FILT_CYCLES` consecutive clock cycles, so short glitches never reach the flag. Arming a line whose input is already high counts as a rising edge. Software must therefore arm lines while they are low if it wants the flag set on real edges only.

Top module: `key_port_irq`

## Requirements
- R1: A read of address 0x0E0 returns the synchronized key levels, with bit i equal to key line i (1 = high). A pin change is visible in the read data after two rising clock edges.
- R2: The enable register at 0x0E8 is readable and writable, and it resets to 0. Bit i set to 1 arms line i. Bit i set to 0 masks line i, and a masked line never sets the flag.
- R3: Writes to 0x0E0 and to 0x0ED change no state. The factor flag reads back as bit 0 of address 0x0ED.
- R4: On a pin with the noise rejector bypassed, a rising edge on an armed line sets the flag. `irq_o` goes high after the third rising clock edge following the pin change.
- R5: A read of 0x0ED returns the flag and clears it on that read's clock edge.
- R6: Writing an enable bit to 1 while its line is already high sets the flag on the clock edge after the write edge.
- R7: On a pin with the noise rejector selected, a level change must hold for `FILT_CYCLES` consecutive synchronized samples before it passes. A rising edge then raises `irq_o` after `FILT_CYCLES`+3 edges. A shorter pulse never sets the flag.
- R8: The noise rejector is selected per pin. A bypassed pin keeps the R4 latency whatever the other pins select.
- R9: If the flag is set in the same cycle as a read of 0x0ED, the set wins and the flag stays 1.
- R10: Bits with no function read as 0. Unmapped addresses read as 0. `rdata_o` is 0 while `rd_i` is low.
- R11: `irq_o` equals the factor flag. After reset the flag and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | NUM_KEYS | External key/switch lines |
| filt_sel_i | input | NUM_KEYS | Per-pin noise rejector select (1 = filter) |
| addr_i | input | ADDR_W | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data (combinational during rd_i) |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational and is sampled 1 ns after the read strobe is driven. A read clears the flag on the following rising edge, and `irq_o` is checked at the next falling edge. Key levels become readable after two edges. On a bypassed pin the flag follows two edges after the level and reaches `irq_o` after the third edge. On a filtered pin it arrives after `FILT_CYCLES`+3 edges. The bench checks `irq_o` one cycle before each due edge to confirm it is still low, then checks it on the due edge to confirm it is high. An arming write sets the flag one edge after the write edge. The same-cycle set-and-clear case is provoked by placing a flag read in the cycle where the edge is pending.

// File: rtl/key_port_pkg.sv
package key_port_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_PORT = 12'h0E0;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 12'h0E8;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 12'h0ED;
endpackage

// File: rtl/key_sync.sv
module key_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  // R1: second stage follows first stage one cycle later
  p_sync_chain_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> s2_q == $past(s1_q));
endmodule

// File: rtl/key_filter.sv
module key_filter #(
  parameter int W           = 4,
  parameter int FILT_CYCLES = 1000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] q_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] cnt_q;
    logic          filt_q;
    logic          diff;

    assign diff = d_i[i] ^ filt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        filt_q <= 1'b0;
      end else if (!sel_i[i]) begin
        // bypass: track input so a later switch to filtering starts clean
        cnt_q  <= '0;
        filt_q <= d_i[i];
      end else if (!diff) begin
        cnt_q  <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q  <= '0;
        filt_q <= d_i[i];
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end

    assign q_o[i] = sel_i[i] ? filt_q : d_i[i];

    // R7: filtered level moves only after a full run of differing samples
    p_filt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(sel_i[i]) && (filt_q != $past(filt_q))) |-> $past(cnt_q) == LAST);
    // R7: counter never passes its limit
    p_filt_cnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);
  end
endmodule

// File: rtl/key_edge_flag.sv
module key_edge_flag #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_i,
  output logic         flag_o
);
  logic [W-1:0] gated, prev_q, rise;
  logic         flag_q;

  assign gated = lvl_i & en_i;
  assign rise  = gated & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= gated;
      if (|rise)      flag_q <= 1'b1;  // set beats clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R4: flag rises only after an armed rising level
  p_flag_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(|rise));
  // R9: a pending edge always lands, even against a clear
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> flag_q);
  // R5: read clears the flag when nothing new arrives
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(|rise)) |=> !flag_q);
endmodule

// File: rtl/key_port_irq.sv
module key_port_irq
  import key_port_pkg::*;
#(
  parameter int NUM_KEYS    = 4,
  parameter int FILT_CYCLES = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] key_i,
  input  logic [NUM_KEYS-1:0] filt_sel_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o
);
  logic [NUM_KEYS-1:0] sync_lvl, filt_lvl, en_q;
  logic                en_wr, flag_rd, flag;
  logic [DATA_W-1:0]   port_word, en_word;

  key_sync #(.W(NUM_KEYS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (key_i),
    .q_o   (sync_lvl)
  );

  key_filter #(.W(NUM_KEYS), .FILT_CYCLES(FILT_CYCLES)) u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_lvl),
    .sel_i (filt_sel_i),
    .q_o   (filt_lvl)
  );

  assign en_wr   = wr_i && (addr_i == ADDR_EN);
  assign flag_rd = rd_i && (addr_i == ADDR_FLAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_wr) en_q <= wdata_i[NUM_KEYS-1:0];
  end

  key_edge_flag #(.W(NUM_KEYS)) u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (filt_lvl),
    .en_i  (en_q),
    .clr_i (flag_rd),
    .flag_o(flag)
  );

  always_comb begin
    port_word = '0;
    en_word   = '0;
    port_word[NUM_KEYS-1:0] = sync_lvl;
    en_word[NUM_KEYS-1:0]   = en_q;
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_PORT: rdata_o = port_word;
        ADDR_EN:   rdata_o = en_word;
        ADDR_FLAG: rdata_o[0] = flag;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign irq_o = flag;

  // R2: enable bits change only through a write to their address
  p_en_write_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q != $past(en_q)) |-> $past(en_wr));
  // R2: with every line masked the request cannot rise
  p_mask_all_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |=> !$rose(irq_o));
  // R10: bus is quiet without a read strobe
  p_idle_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

// File: tb/key_port_irq_test.sv
module key_port_irq_test;
  localparam int NK = 4;
  localparam int FC = 20;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  key = '0;
  logic [3:0]  filt_sel = '0;
  logic [11:0] addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wdata = '0;
  logic [3:0]  rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  key_port_irq #(.NUM_KEYS(NK), .FILT_CYCLES(FC)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .key_i     (key),
    .filt_sel_i(filt_sel),
    .addr_i    (addr),
    .rd_i      (rd_en),
    .wr_i      (wr_en),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [3:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [3:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [3:0] d;
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R11 reset state
    chk("R11 reset irq", irq, 0);
    bus_rd(12'h0E8, d); chk("R2 reset enable", d, 0);
    bus_rd(12'h0ED, d); chk("R11 reset flag", d, 0);
    bus_rd(12'h0E0, d); chk("R1 reset port", d, 0);

    // R1 level sweep
    for (int v = 0; v < 16; v++) begin
      key = 4'(v);
      step(2);
      bus_rd(12'h0E0, d); chk("R1 port level", d, v);
    end
    key = '0; step(3);

    // R2 enable sweep
    for (int v = 0; v < 16; v++) begin
      bus_wr(12'h0E8, 4'(v));
      bus_rd(12'h0E8, d); chk("R2 enable readback", d, v);
    end
    bus_wr(12'h0E8, 4'h0);

    // R3 write to port ignored
    key = 4'hA; step(2);
    bus_wr(12'h0E0, 4'h5);
    bus_rd(12'h0E0, d); chk("R3 port write ignored", d, 4'hA);
    bus_rd(12'h0E8, d); chk("R3 port write leaves enable", d, 0);
    key = '0; step(3);

    // R4 / R5 each line, bypass
    for (int i = 0; i < NK; i++) begin
      bus_wr(12'h0E8, 4'(1 << i));
      key = 4'(1 << i);
      step(2); chk("R4 not yet at edge 2", irq, 0);
      step(1); chk("R4 irq at edge 3", irq, 1);
      bus_rd(12'h0ED, d); chk("R5 flag read value", d, 1);
      chk("R5 cleared by read", irq, 0);
      key = '0; step(3);
    end

    // R2 masked lines
    for (int i = 0; i < NK; i++) begin
      bus_wr(12'h0E8, ~4'(1 << i));
      key = 4'(1 << i);
      step(4); chk("R2 masked line no irq", irq, 0);
      key = '0; step(3);
    end

    // R3 write to flag ignored
    bus_wr(12'h0E8, 4'h1);
    key = 4'h1; step(3);
    chk("R4 flag set before write", irq, 1);
    bus_wr(12'h0ED, 4'h0); chk("R3 flag write ignored", irq, 1);
    bus_rd(12'h0ED, d); chk("R10 flag unused bits", d, 1);
    key = '0; bus_wr(12'h0E8, 4'h0); step(3);

    // R6 arming while high
    key = 4'hF; step(4);
    chk("R6 unarmed high no irq", irq, 0);
    for (int i = 0; i < NK; i++) begin
      bus_wr(12'h0E8, 4'(1 << i));
      chk("R6 not before next edge", irq, 0);
      step(1); chk("R6 arm while high sets flag", irq, 1);
      bus_rd(12'h0ED, d);
    end
    bus_wr(12'h0E8, 4'h0);
    bus_wr(12'h0E8, 4'h8);
    step(1); chk("R6 clear then set sets again", irq, 1);
    bus_rd(12'h0ED, d);
    bus_wr(12'h0E8, 4'h0); key = '0; step(3);

    // R9 set and read in same cycle
    bus_wr(12'h0E8, 4'h1);
    key = 4'h1; step(2);
    bus_rd(12'h0ED, d); chk("R9 read before set", d, 0);
    chk("R9 set wins over clear", irq, 1);
    bus_rd(12'h0ED, d); chk("R9 flag kept", d, 1);
    chk("R5 cleared after second read", irq, 0);
    key = '0; step(3);

    // R7 filtered pin 0
    filt_sel = 4'h1; step(2);
    key = 4'h1; step(FC - 1); key = '0;
    step(FC + 5); chk("R7 short pulse rejected", irq, 0);
    key = 4'h1;
    step(FC + 2); chk("R7 not before FC+3", irq, 0);
    step(1); chk("R7 irq at FC+3", irq, 1);
    bus_rd(12'h0ED, d);
    bus_rd(12'h0E0, d); chk("R1 port unfiltered", d, 1);
    key = '0; step(FC + 5);

    // R8 bypassed pin beside filtered pin
    bus_wr(12'h0E8, 4'h2);
    key = 4'h2;
    step(2); chk("R8 bypass pin edge 2", irq, 0);
    step(1); chk("R8 bypass pin edge 3", irq, 1);
    bus_rd(12'h0ED, d);
    key = '0; step(3);

    // R10 unmapped and idle
    bus_rd(12'h0E4, d); chk("R10 unmapped reads 0", d, 0);
    key = 4'hF; step(3);
    chk("R10 idle bus 0", rdata, 0);
    finish_run();
  end
endmodule